// File: doc/BRIEF.md
# Link State Transition Trace Monitor

This block watches the 6-bit training-state code that a serial-link controller reports and keeps a debug record of how that code moves. The code is registered once. A change between two registered samples counts as a transition. On each transition the block logs a 32-bit entry in an internal first-in, first-out trace. The entry gives the state just entered and how long the state being left was held. When the trace fills, new entries are dropped and the oldest ones stay in place.

Software reaches the block through a small word-addressed register port with a one-cycle read latency. Through this port it can pop trace entries one by one, flush the trace, read a flag for every state code entered since the last clear, read the current state and the number of transitions, and name up to four state codes that the trace does not log. A dwell timer counts the cycles spent in the current state. It starts again at every transition and saturates at its maximum value instead of wrapping.

Top module: `lts_trace_mon`

## Requirements
- R1: After the synchronous active-high reset, the status word reads 0x4000_0000 (current state 0x00, empty), the transition count and both visited words read 0, the skip word reads 0, and a pop read returns 0.
- R2: A transition is a registered sample of `link_state` that differs from the previous registered sample. Each stored transition makes an entry with the new state code in bits [5:0], bit 7 set as the valid mark and bit 6 clear.
- R3: Entry bits [31:8] hold the number of clock cycles the input held the state being left. The count saturates at 2^DWELL_W-1, and the timer restarts at every transition, whether or not the entry is stored.
- R4: The trace holds DEPTH entries. Once it is full, further transitions are dropped and the stored entries keep their order, oldest first.
- R5: A read at word offset 0x2 returns the oldest entry and removes it. A read of an empty trace returns 0, with bit 7 clear.
- R6: The skip word at offset 0x4 is read/write and holds four slots, one per byte: code in bits [5:0] and enable in bit 7. A transition into a code held by an enabled slot is not stored. A disabled slot has no effect.
- R7: The visited words at offsets 0x5 (codes 0..31) and 0x6 (codes 32..63) set bit n when a transition enters code n.
- R8: The transition count at offset 0x1 increments on every transition, stored, skipped or dropped.
- R9: A write to offset 0x7 with bit 0 set clears the visited flags and the transition count and leaves the skip word unchanged. Bit 1 set empties the trace.
- R10: The status word at offset 0x0 carries the current state in [5:0], the trace level from bit 16 upward, the empty flag in bit 30 and the full flag in bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_state | input | 6 | Training-state code from the link controller |
| reg_addr | input | ADDR_W | Register word offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |

## Verification
A code change on `link_state` reaches the trace on the second rising edge after it is applied: one edge for the input register and one for the comparison. The current state, count and visited flags change on that same edge. Read data appears on the edge that samples `reg_rd` and is looked at on the following falling edge. The bench therefore lets the input settle for several cycles before it reads, and it drains the trace only while the input is steady, so that each pop sees the same queue the reference model holds. Dwell values are predicted from a cycle counter taken at the falling edge when each code is applied.

// File: rtl/lts_trace_pkg.sv
package lts_trace_pkg;

  localparam int ST_W      = 6;
  localparam int ENTRY_W   = 32;
  localparam int DW_MAX_W  = 24;
  localparam int NSLOT     = 4;
  localparam int VALID_BIT = 7;

  localparam int OFS_STATUS  = 0;
  localparam int OFS_COUNT   = 1;
  localparam int OFS_POP     = 2;
  localparam int OFS_SKIP    = 4;
  localparam int OFS_VIS_LO  = 5;
  localparam int OFS_VIS_HI  = 6;
  localparam int OFS_CLEAR   = 7;

  typedef logic [ST_W-1:0] lstate_t;

  // Saturating increment used by the dwell timer.
  function automatic logic [DW_MAX_W-1:0] dwell_sat_inc(input logic [DW_MAX_W-1:0] v,
                                                        input logic [DW_MAX_W-1:0] lim);
    return (v >= lim) ? lim : v + 1'b1;
  endfunction

  // Trace entry layout: dwell in [31:8], valid mark at bit 7, state in [5:0].
  function automatic logic [ENTRY_W-1:0] pack_entry(input lstate_t st,
                                                    input logic [DW_MAX_W-1:0] dw);
    return {dw, 1'b1, 1'b0, st};
  endfunction

endpackage

// File: rtl/lts_dwell_timer.sv
module lts_dwell_timer
  import lts_trace_pkg::*;
#(
  parameter int DWELL_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                restart,
  output logic [DWELL_W-1:0]  run_o,
  output logic [DW_MAX_W-1:0] leave_o
);
  localparam logic [DWELL_W-1:0] LIM = '1;

  logic [DWELL_W-1:0] cnt;

  // Value reported for the state being left: cycles held, saturated.
  assign leave_o = dwell_sat_inc(DW_MAX_W'(cnt), DW_MAX_W'(LIM));
  assign run_o   = cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else                cnt <= DWELL_W'(dwell_sat_inc(DW_MAX_W'(cnt), DW_MAX_W'(LIM)));
  end
endmodule

// File: rtl/lts_skip_match.sv
module lts_skip_match
  import lts_trace_pkg::*;
(
  input  logic [ENTRY_W-1:0] cfg,
  input  lstate_t            st,
  output logic               hit
);
  logic [NSLOT-1:0] slot_hit;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign slot_hit[i] = cfg[8*i+7] && (cfg[8*i +: ST_W] == st);
  end

  assign hit = |slot_hit;
endmodule

// File: rtl/lts_trace_fifo.sv
module lts_trace_fifo #(
  parameter int DEPTH = 1024,
  parameter int W     = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      level <= level + LVL_W'(do_push) - LVL_W'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/lts_trace_mon.sv
module lts_trace_mon
  import lts_trace_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int DWELL_W = 24,
  parameter int ADDR_W  = 4,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ST_W-1:0]     link_state,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ENTRY_W-1:0]  reg_wdata,
  output logic [ENTRY_W-1:0]  reg_rdata
);
  localparam int NSTATE = 1 << ST_W;

  // Sampled input and tracked state
  lstate_t s_q, cur_st;
  logic    change;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_q    <= '0;
      cur_st <= '0;
    end else begin
      s_q    <= link_state;
      cur_st <= s_q;
    end
  end

  assign change = (s_q != cur_st);

  // Register decode, named for the checker
  logic sel_count, sel_pop, sel_skip, sel_vlo, sel_vhi, sel_clr, sel_stat;
  assign sel_stat  = (reg_addr == ADDR_W'(OFS_STATUS));
  assign sel_count = (reg_addr == ADDR_W'(OFS_COUNT));
  assign sel_pop   = (reg_addr == ADDR_W'(OFS_POP));
  assign sel_skip  = (reg_addr == ADDR_W'(OFS_SKIP));
  assign sel_vlo   = (reg_addr == ADDR_W'(OFS_VIS_LO));
  assign sel_vhi   = (reg_addr == ADDR_W'(OFS_VIS_HI));
  assign sel_clr   = (reg_addr == ADDR_W'(OFS_CLEAR));

  logic clr_stats, flush, fifo_pop;
  assign clr_stats = reg_wr && sel_clr && reg_wdata[0];
  assign flush     = reg_wr && sel_clr && reg_wdata[1];
  assign fifo_pop  = reg_rd && sel_pop;

  // Skip configuration
  logic [ENTRY_W-1:0] skip_cfg;
  always_ff @(posedge clk) begin
    if (rst)                   skip_cfg <= '0;
    else if (reg_wr && sel_skip) skip_cfg <= reg_wdata;
  end

  logic skip_hit;
  lts_skip_match u_skip (
    .cfg (skip_cfg),
    .st  (s_q),
    .hit (skip_hit)
  );

  // Dwell timer
  logic [DWELL_W-1:0]  dwell_run;
  logic [DW_MAX_W-1:0] dwell_leave;
  lts_dwell_timer #(.DWELL_W(DWELL_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (change),
    .run_o   (dwell_run),
    .leave_o (dwell_leave)
  );

  // Trace storage
  logic               store;
  logic [ENTRY_W-1:0] fifo_dout;
  logic [LVL_W-1:0]   level;
  logic               full, empty;

  assign store = change && !skip_hit;

  lts_trace_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .flush (flush),
    .push  (store),
    .pop   (fifo_pop),
    .din   (pack_entry(s_q, dwell_leave)),
    .dout  (fifo_dout),
    .level (level),
    .full  (full),
    .empty (empty)
  );

  // Visited flags and transition count
  logic [NSTATE-1:0]  visited;
  logic [ENTRY_W-1:0] tcount;

  always_ff @(posedge clk) begin
    if (rst || clr_stats) begin
      visited <= '0;
      tcount  <= '0;
    end else if (change) begin
      visited[s_q] <= 1'b1;
      tcount       <= tcount + 1'b1;
    end
  end

  // Read mux
  logic [ENTRY_W-1:0] stat_word, rd_mux;
  always_comb begin
    stat_word            = '0;
    stat_word[ST_W-1:0]  = cur_st;
    stat_word[16 +: LVL_W] = level;
    stat_word[30]        = empty;
    stat_word[31]        = full;
  end

  always_comb begin
    rd_mux = '0;
    if (sel_stat)  rd_mux = stat_word;
    if (sel_count) rd_mux = tcount;
    if (sel_pop)   rd_mux = empty ? '0 : fifo_dout;
    if (sel_skip)  rd_mux = skip_cfg;
    if (sel_vlo)   rd_mux = visited[31:0];
    if (sel_vhi)   rd_mux = visited[63:32];
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/lts_trace_mon_chk.sv
module lts_trace_mon_chk
  import lts_trace_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int DWELL_W = 24,
  parameter int ADDR_W  = 4,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_rd,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [ENTRY_W-1:0] reg_wdata,
  input logic [ENTRY_W-1:0] reg_rdata,
  input logic               change,
  input logic               skip_hit,
  input logic               fifo_pop,
  input logic               flush,
  input logic [LVL_W-1:0]   level,
  input logic               full,
  input logic               empty,
  input logic [DWELL_W-1:0] dwell_run,
  input logic [63:0]        visited,
  input logic [ENTRY_W-1:0] tcount
);
  assert_level_bound_R4: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(DEPTH));

  assert_full_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (full && !fifo_pop && !flush) |=> full);

  assert_store_grows_R2: assert property (@(posedge clk) disable iff (rst)
    (change && !skip_hit && !full && !flush && !fifo_pop) |=> (level == $past(level) + 1'b1));

  assert_skip_no_store_R6: assert property (@(posedge clk) disable iff (rst)
    (change && skip_hit && !fifo_pop && !flush) |=> $stable(level));

  assert_timer_restart_R3: assert property (@(posedge clk) disable iff (rst)
    change |=> (dwell_run == '0));

  assert_empty_read_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADDR_W'(OFS_POP) && empty) |=> (reg_rdata[VALID_BIT] == 1'b0));

  assert_clear_stats_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(OFS_CLEAR) && reg_wdata[0]) |=> (visited == '0 && tcount == '0));

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
endmodule

bind lts_trace_mon lts_trace_mon_chk #(
  .DEPTH(DEPTH), .DWELL_W(DWELL_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .change(change), .skip_hit(skip_hit),
  .fifo_pop(fifo_pop), .flush(flush), .level(level), .full(full), .empty(empty),
  .dwell_run(dwell_run), .visited(visited), .tcount(tcount)
);

// File: tb/test_lts_trace_mon.sv
module test_lts_trace_mon;
  localparam int DEPTH = 16;
  localparam int DW_W  = 6;
  localparam int DW_MAX = (1 << DW_W) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  link_state = '0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  always #2.5 clk = ~clk;

  lts_trace_mon #(.DEPTH(DEPTH), .DWELL_W(DW_W), .ADDR_W(4)) i_lts_trace_mon (
    .clk(clk), .rst(rst), .link_state(link_state), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  int tests = 0, fails = 0;
  int cyc = 0;

  // Reference model state
  logic [31:0] exp_q[$];
  bit          known_q[$];
  logic [5:0]  m_cur = '0;
  int          m_stamp = 0;
  bit          m_first = 1'b1;
  logic [31:0] m_skip = '0;
  logic [63:0] m_vis = '0;
  int          m_cnt = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired act=%0d exp=done", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit skip_m(input logic [5:0] c);
    for (int i = 0; i < 4; i++)
      if (m_skip[8*i+7] && m_skip[8*i +: 6] == c) return 1'b1;
    return 1'b0;
  endfunction

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic go(input logic [5:0] code, input int hold);
    int dw;
    @(negedge clk);
    if (code != m_cur) begin
      dw = cyc - m_stamp;
      if (dw > DW_MAX) dw = DW_MAX;
      m_stamp = cyc;
      m_cnt++;
      m_vis[code] = 1'b1;
      if (!skip_m(code) && exp_q.size() < DEPTH) begin
        exp_q.push_back({24'(dw), 2'b10, code});
        known_q.push_back(!m_first);
      end
      m_first = 1'b0;
      m_cur = code;
    end
    link_state = code;
    repeat (hold) @(posedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_stats(input string tag);
    logic [31:0] d;
    rd(4'h1, d); check({"R8 count ", tag}, d, m_cnt);
    rd(4'h5, d); check({"R7 visited lo ", tag}, d, m_vis[31:0]);
    rd(4'h6, d); check({"R7 visited hi ", tag}, d, m_vis[63:32]);
  endtask

  task automatic drain(input string tag);
    logic [31:0] d, e;
    bit k;
    rd(4'h0, d);
    check({"R10 status ", tag}, d,
          {exp_q.size() == DEPTH, exp_q.size() == 0, 9'd0, 5'(exp_q.size()), 10'd0, m_cur});
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front(); k = known_q.pop_front();
      rd(4'h2, d);
      if (!k) begin d[31:8] = '0; e[31:8] = '0; end
      check({"R2 R3 R4 entry ", tag}, d, e);
    end
    rd(4'h2, d); check({"R5 empty pop ", tag}, d, 32'h0);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_stamp = cyc;
    // R1 reset state
    rd(4'h0, d); check("R1 status", d, 32'h4000_0000);
    rd(4'h1, d); check("R1 count", d, 0);
    rd(4'h5, d); check("R1 visited lo", d, 0);
    rd(4'h6, d); check("R1 visited hi", d, 0);
    rd(4'h4, d); check("R1 skip", d, 0);
    rd(4'h2, d); check("R1 pop", d, 0);

    // R2 R3 directed path up to the active state 0x10
    go(6'h02, 5); go(6'h04, 7); go(6'h05, 3); go(6'h10, 4);
    go(6'h21, 1); go(6'h22, 1); go(6'h23, 2);
    settle();
    check_stats("directed");
    drain("directed");

    // R3 saturation of the dwell field
    go(6'h07, 100); go(6'h08, 4);
    settle(); drain("saturate");

    // R6 skip slots: slot0 enabled 0x0B, slot1 disabled 0x0C, slot2 enabled 0x3F
    wr(4'h4, 32'h00BF_0C8B);
    rd(4'h4, d); check("R6 skip readback", d, 32'h00BF_0C8B);
    m_skip = 32'h00BF_0C8B;
    go(6'h0B, 3); go(6'h0C, 5); go(6'h3F, 2); go(6'h11, 3);
    settle(); check_stats("skip"); drain("skip");

    // R4 overflow: more transitions than DEPTH
    for (int i = 0; i < DEPTH + 5; i++) go(6'(i % 2 ? 6'h12 : 6'h13), 2);
    settle(); drain("full");

    // R9 clear stats keeps skip, flush empties trace
    wr(4'h7, 32'h1); m_vis = '0; m_cnt = 0;
    check_stats("clear");
    rd(4'h4, d); check("R9 skip kept", d, 32'h00BF_0C8B);
    go(6'h01, 3); go(6'h02, 3); settle();
    wr(4'h7, 32'h2); exp_q.delete(); known_q.delete();
    rd(4'h2, d); check("R9 flush pop", d, 0);
    rd(4'h0, d); check("R9 R10 status after flush", d, {2'b01, 24'd0, m_cur});

    // Random bursts
    void'($urandom(32'd1234));
    for (int b = 0; b < 12; b++) begin
      m_skip = {1'($urandom_range(0,1)), 1'b0, 6'($urandom_range(0,7)),
                1'($urandom_range(0,1)), 1'b0, 6'($urandom_range(0,7)),
                8'h00, 1'b1, 1'b0, 6'($urandom_range(0,7))};
      wr(4'h4, m_skip);
      for (int t = 0; t < int'($urandom_range(4, 26)); t++)
        go(6'($urandom_range(0, 7)), ((t % 9) == 8) ? 70 : $urandom_range(1, 6));
      settle();
      check_stats("random");
      drain("random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule